// File: doc/BRIEF.md
# Two-Wire Bus Condition Monitor

This block sits beside a two-wire serial bus controller and watches the data (SDA) and clock (SCL) lines. Each line is first brought into the local clock domain by a short synchronizer. It can then pass through a clock-counting spike filter, which one control bit switches on or off for both lines at once. From the resulting clean levels the block detects START and STOP conditions and gives a one-cycle pulse for each. It also shows the synchronized line levels as status bits.

The block keeps an event flag, an error flag and a level-held interrupt request. Software clears all three with one strobe. The event flag goes high for a completed byte transfer, a bus error, an arbitration loss or an unprocessed request, and each of these also raises the interrupt. A STOP seen on the bus can raise the interrupt too when its enable is set, but it leaves the event flag low. Software can read this to tell a "bus free" interrupt apart from a transfer interrupt.

When the local master asks for a repeated START or a STOP, the block remembers the request. If SCL falls on the bus before the requested condition appears, the request counts as unprocessed. The block then sets its own flag, which also forces the error flag. This check only runs while the advanced-features enable is high.

Top module: `i2c_cond_mon`

## Requirements
- R1: With `filt_en` = 0, a level change on `sda_in` or `scl_in` reaches `sda_filt` or `scl_filt` after exactly SYNC_STAGES clock edges (2 by default), and a one-cycle pulse passes through.
- R2: With `filt_en` = 1, a new level reaches the filtered outputs only after it has been present at the synchronizer output for STABLE_CYC consecutive edges (2 by default, so 4 edges in total). Shorter pulses on either line never reach the filtered outputs.
- R3: `start_pulse` is high for exactly one cycle when filtered SDA goes from 1 to 0 while filtered SCL is 1 both before and after the change.
- R4: `stop_pulse` is high for exactly one cycle when filtered SDA goes from 0 to 1 while filtered SCL is 1 both before and after the change.
- R5: `sda_level` and `scl_level` always equal the synchronized line levels, SYNC_STAGES edges after the inputs. This holds whatever the filter setting and also while a spike is being rejected.
- R6: A STOP pulse sets `irq` on the next edge when `stop_irq_en` = 1, and has no effect on `irq` when `stop_irq_en` = 0.
- R7: A STOP leaves `evt_flag` at 0. A one-cycle `byte_done`, `bus_err` or `arb_lost` strobe sets `evt_flag` and `irq` on the next edge, and `bus_err` and `arb_lost` also set `err_flag`.
- R8: When `adv_en` = 1 and a `rstart_req` or `stop_req` strobe is pending, the request clears if the matching START or STOP pulse comes next. If a falling edge of filtered SCL comes first, `unproc_flag`, `evt_flag` and `irq` are set on the following edge.
- R9: Whenever `unproc_flag` is 1, `err_flag` is also 1.
- R10: While `adv_en` = 0, `unproc_flag` is 0 from the next edge on, pending requests are dropped and requests are ignored.
- R11: After reset all flags and `irq` are 0, both filtered outputs and both levels are 1, and no pulse is active. Flags and `irq` stay set until a `flag_clr` strobe. A new set event in the same cycle as `flag_clr` wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sda_in | input | 1 | Sampled SDA line level |
| scl_in | input | 1 | Sampled SCL line level |
| filt_en | input | 1 | Spike filter enable for both lines |
| stop_irq_en | input | 1 | Interrupt on bus STOP enable |
| adv_en | input | 1 | Advanced-features enable (unprocessed-request check) |
| rstart_req | input | 1 | One-cycle strobe: local master requests a repeated START |
| stop_req | input | 1 | One-cycle strobe: local master requests a STOP |
| byte_done | input | 1 | One-cycle strobe: byte transfer completed |
| bus_err | input | 1 | One-cycle strobe: bus error detected |
| arb_lost | input | 1 | One-cycle strobe: arbitration lost |
| flag_clr | input | 1 | One-cycle strobe: clear flags and interrupt |
| sda_filt | output | 1 | Filtered SDA level |
| scl_filt | output | 1 | Filtered SCL level |
| start_pulse | output | 1 | START detected (one cycle) |
| stop_pulse | output | 1 | STOP detected (one cycle) |
| sda_level | output | 1 | Synchronized SDA level (status) |
| scl_level | output | 1 | Synchronized SCL level (status) |
| evt_flag | output | 1 | Byte or error event flag |
| err_flag | output | 1 | Error flag |
| unproc_flag | output | 1 | Unprocessed request flag |
| irq | output | 1 | Level-held interrupt request |

## Verification
Line levels are due SYNC_STAGES edges after an input change. Filtered levels are due at that same edge with the filter off, and STABLE_CYC edges later with it on. The START and STOP pulses show up in the same cycle as the filtered change, and every flag and the interrupt follow one edge after their cause. The bench drives inputs 2 ns after a rising edge and samples on the falling edge. A behavioural model replays the same edge sequence and is compared with all outputs in every cycle. Directed checks count falling edges from a drive point to test the exact filter and synchronizer latency, and they keep each bus level for eight cycles, well beyond the longest path, before reading the flags.

// File: rtl/i2c_cond_mon_pkg.sv
package i2c_cond_mon_pkg;
   localparam int LINE_SDA  = 0;
   localparam int LINE_SCL  = 1;
   localparam int NUM_LINES = 2;

   typedef enum logic {
      PEND_RSTART = 1'b0,
      PEND_STOP   = 1'b1
   } pend_kind_e;
endpackage

// File: rtl/icm_line_filter.sv
module icm_line_filter #(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic filt_en,
   input  logic line_in,
   output logic line_sync,
   output logic line_filt
);
   localparam int CNT_W = (STABLE_CYC < 2) ? 1 : $clog2(STABLE_CYC);

   logic [SYNC_STAGES-1:0] sync_sh;
   logic                   held_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_sh <= '1;
      else        sync_sh <= {sync_sh[SYNC_STAGES-2:0], line_in};
   end

   assign line_sync = sync_sh[SYNC_STAGES-1];

   generate
      if (STABLE_CYC == 1) begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) held_q <= 1'b1;
            else        held_q <= line_sync;
         end
      end else begin : g_count
         logic [CNT_W-1:0] run_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               held_q  <= 1'b1;
               run_cnt <= '0;
            end else if (!filt_en) begin
               held_q  <= line_sync;
               run_cnt <= '0;
            end else if (line_sync != held_q) begin
               if (run_cnt == CNT_W'(STABLE_CYC - 1)) begin
                  held_q  <= line_sync;
                  run_cnt <= '0;
               end else begin
                  run_cnt <= run_cnt + 1'b1;
               end
            end else begin
               run_cnt <= '0;
            end
         end
      end
   endgenerate

   assign line_filt = filt_en ? held_q : line_sync;
endmodule

// File: rtl/icm_cond_detect.sv
module icm_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_f,
   input  logic scl_f,
   output logic start_p,
   output logic stop_p,
   output logic scl_fall
);
   logic sda_d, scl_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sda_d <= 1'b1;
         scl_d <= 1'b1;
      end else begin
         sda_d <= sda_f;
         scl_d <= scl_f;
      end
   end

   assign start_p  =  sda_d & ~sda_f & scl_f & scl_d;
   assign stop_p   = ~sda_d &  sda_f & scl_f & scl_d;
   assign scl_fall =  scl_d & ~scl_f;
endmodule

// File: rtl/icm_req_track.sv
module icm_req_track
   import i2c_cond_mon_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic adv_en,
   input  logic rstart_req,
   input  logic stop_req,
   input  logic start_p,
   input  logic stop_p,
   input  logic scl_fall,
   input  logic clr,
   output logic unproc_set,
   output logic unproc_flag
);
   logic       pend_q;
   pend_kind_e kind_q;
   logic       new_req, hit;

   assign new_req    = stop_req | rstart_req;
   assign hit        = pend_q & (((kind_q == PEND_RSTART) & start_p) |
                                 ((kind_q == PEND_STOP)   & stop_p));
   assign unproc_set = adv_en & pend_q & ~new_req & ~hit & scl_fall;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q      <= 1'b0;
         kind_q      <= PEND_RSTART;
         unproc_flag <= 1'b0;
      end else if (!adv_en) begin
         pend_q      <= 1'b0;
         unproc_flag <= 1'b0;
      end else begin
         if (stop_req) begin
            pend_q <= 1'b1;
            kind_q <= PEND_STOP;
         end else if (rstart_req) begin
            pend_q <= 1'b1;
            kind_q <= PEND_RSTART;
         end else if (hit || unproc_set) begin
            pend_q <= 1'b0;
         end
         if (unproc_set)  unproc_flag <= 1'b1;
         else if (clr)    unproc_flag <= 1'b0;
      end
   end
endmodule

// File: rtl/i2c_cond_mon.sv
module i2c_cond_mon
   import i2c_cond_mon_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int STABLE_CYC  = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sda_in,
   input  logic scl_in,
   input  logic filt_en,
   input  logic stop_irq_en,
   input  logic adv_en,
   input  logic rstart_req,
   input  logic stop_req,
   input  logic byte_done,
   input  logic bus_err,
   input  logic arb_lost,
   input  logic flag_clr,
   output logic sda_filt,
   output logic scl_filt,
   output logic start_pulse,
   output logic stop_pulse,
   output logic sda_level,
   output logic scl_level,
   output logic evt_flag,
   output logic err_flag,
   output logic unproc_flag,
   output logic irq
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (STABLE_CYC < 1) begin : g_bad_stable
      $error("STABLE_CYC must be at least 1");
   end

   logic [NUM_LINES-1:0] raw_vec, sync_vec, filt_vec;
   logic scl_fall, unproc_set;
   logic evt_set, err_set, irq_set;

   assign raw_vec[LINE_SDA] = sda_in;
   assign raw_vec[LINE_SCL] = scl_in;

   generate
      for (genvar li = 0; li < NUM_LINES; li++) begin : g_line
         icm_line_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .STABLE_CYC (STABLE_CYC)
         ) u_filt (
            .clk      (clk),
            .rst_n    (rst_n),
            .filt_en  (filt_en),
            .line_in  (raw_vec[li]),
            .line_sync(sync_vec[li]),
            .line_filt(filt_vec[li])
         );
      end
   endgenerate

   assign sda_filt  = filt_vec[LINE_SDA];
   assign scl_filt  = filt_vec[LINE_SCL];
   assign sda_level = sync_vec[LINE_SDA];
   assign scl_level = sync_vec[LINE_SCL];

   icm_cond_detect u_det (
      .clk     (clk),
      .rst_n   (rst_n),
      .sda_f   (sda_filt),
      .scl_f   (scl_filt),
      .start_p (start_pulse),
      .stop_p  (stop_pulse),
      .scl_fall(scl_fall)
   );

   icm_req_track u_req (
      .clk        (clk),
      .rst_n      (rst_n),
      .adv_en     (adv_en),
      .rstart_req (rstart_req),
      .stop_req   (stop_req),
      .start_p    (start_pulse),
      .stop_p     (stop_pulse),
      .scl_fall   (scl_fall),
      .clr        (flag_clr),
      .unproc_set (unproc_set),
      .unproc_flag(unproc_flag)
   );

   assign evt_set = byte_done | bus_err | arb_lost | unproc_set;
   assign err_set = bus_err | arb_lost | unproc_set;
   assign irq_set = evt_set | (stop_pulse & stop_irq_en);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         evt_flag <= 1'b0;
         err_flag <= 1'b0;
         irq      <= 1'b0;
      end else begin
         evt_flag <= evt_set | (evt_flag & ~flag_clr);
         err_flag <= err_set | (err_flag & ~flag_clr);
         irq      <= irq_set | (irq & ~flag_clr);
      end
   end
endmodule

// File: rtl/icm_checker.sv
module icm_checker (
   input logic clk,
   input logic rst_n,
   input logic filt_en,
   input logic stop_irq_en,
   input logic adv_en,
   input logic flag_clr,
   input logic sda_filt,
   input logic scl_filt,
   input logic start_pulse,
   input logic stop_pulse,
   input logic evt_flag,
   input logic err_flag,
   input logic unproc_flag,
   input logic irq
);
   AST_START_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      start_pulse |-> (scl_filt && !sda_filt));                       // R3
   AST_START_STOP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(start_pulse && stop_pulse));                                  // R3
   AST_STOP_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      stop_pulse |-> (scl_filt && sda_filt));                         // R4
   AST_STOP_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_pulse && stop_irq_en) |=> irq);                           // R6
   AST_EVT_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
      evt_flag |-> irq);                                              // R7
   AST_UNPROC_FORCES_ERR: assert property (@(posedge clk) disable iff (!rst_n)
      unproc_flag |-> err_flag);                                      // R9
   AST_UNPROC_NEEDS_ADV: assert property (@(posedge clk) disable iff (!rst_n)
      !adv_en |=> !unproc_flag);                                      // R10
   AST_IRQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !flag_clr) |=> irq);                                    // R11
endmodule

bind i2c_cond_mon icm_checker u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .filt_en    (filt_en),
   .stop_irq_en(stop_irq_en),
   .adv_en     (adv_en),
   .flag_clr   (flag_clr),
   .sda_filt   (sda_filt),
   .scl_filt   (scl_filt),
   .start_pulse(start_pulse),
   .stop_pulse (stop_pulse),
   .evt_flag   (evt_flag),
   .err_flag   (err_flag),
   .unproc_flag(unproc_flag),
   .irq        (irq)
);

// File: tb/i2c_cond_mon_bench.sv
`timescale 1ns/1ps
module i2c_cond_mon_bench;
   localparam int SYNC = 2;
   localparam int STB  = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sda_in = 1'b1, scl_in = 1'b1;
   logic filt_en = 1'b0, stop_irq_en = 1'b0, adv_en = 1'b0;
   logic rstart_req = 1'b0, stop_req = 1'b0;
   logic byte_done = 1'b0, bus_err = 1'b0, arb_lost = 1'b0, flag_clr = 1'b0;
   logic sda_filt, scl_filt, start_pulse, stop_pulse, sda_level, scl_level;
   logic evt_flag, err_flag, unproc_flag, irq;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   i2c_cond_mon #(.SYNC_STAGES(SYNC), .STABLE_CYC(STB)) u_i2c_cond_mon (
      .clk(clk), .rst_n(rst_n), .sda_in(sda_in), .scl_in(scl_in),
      .filt_en(filt_en), .stop_irq_en(stop_irq_en), .adv_en(adv_en),
      .rstart_req(rstart_req), .stop_req(stop_req), .byte_done(byte_done),
      .bus_err(bus_err), .arb_lost(arb_lost), .flag_clr(flag_clr),
      .sda_filt(sda_filt), .scl_filt(scl_filt), .start_pulse(start_pulse),
      .stop_pulse(stop_pulse), .sda_level(sda_level), .scl_level(scl_level),
      .evt_flag(evt_flag), .err_flag(err_flag), .unproc_flag(unproc_flag),
      .irq(irq)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit q_sda[$] = '{1, 1};
   bit q_scl[$] = '{1, 1};
   bit m_hold[2] = '{1, 1};
   int m_run[2]  = '{0, 0};
   bit m_psda = 1, m_pscl = 1;
   bit m_pend = 0, m_pend_stop = 0;
   bit m_unproc = 0, m_evt = 0, m_err = 0, m_irq = 0;

   function automatic bit lvl_sda(); return q_sda[$]; endfunction
   function automatic bit lvl_scl(); return q_scl[$]; endfunction
   function automatic bit mf_sda(); return filt_en ? m_hold[0] : q_sda[$]; endfunction
   function automatic bit mf_scl(); return filt_en ? m_hold[1] : q_scl[$]; endfunction
   function automatic bit m_start(); return m_psda && !mf_sda() && mf_scl() && m_pscl; endfunction
   function automatic bit m_stop();  return !m_psda && mf_sda() && mf_scl() && m_pscl; endfunction

   always @(posedge clk) begin
      if (!rst_n) begin
         q_sda = '{1, 1}; q_scl = '{1, 1};
         m_hold = '{1, 1}; m_run = '{0, 0};
         m_psda = 1; m_pscl = 1; m_pend = 0; m_pend_stop = 0;
         m_unproc = 0; m_evt = 0; m_err = 0; m_irq = 0;
      end else begin
         bit fs, fc, st, sp, fall, uset;
         bit lv[2];
         fs = mf_sda(); fc = mf_scl();
         st = m_start(); sp = m_stop();
         fall = m_pscl && !fc;
         uset = 0;
         if (!adv_en) begin
            m_pend = 0; m_unproc = 0;
         end else begin
            if (stop_req) begin m_pend = 1; m_pend_stop = 1; end
            else if (rstart_req) begin m_pend = 1; m_pend_stop = 0; end
            else if (m_pend && ((m_pend_stop && sp) || (!m_pend_stop && st))) m_pend = 0;
            else if (m_pend && fall) begin m_pend = 0; uset = 1; end
            m_unproc = uset || (m_unproc && !flag_clr);
         end
         m_err = bus_err || arb_lost || uset || (m_err && !flag_clr);
         m_irq = byte_done || bus_err || arb_lost || uset || (sp && stop_irq_en) ||
                 (m_irq && !flag_clr);
         m_evt = byte_done || bus_err || arb_lost || uset || (m_evt && !flag_clr);
         m_psda = fs; m_pscl = fc;
         lv[0] = q_sda[$]; lv[1] = q_scl[$];
         for (int i = 0; i < 2; i++) begin
            if (!filt_en) begin m_hold[i] = lv[i]; m_run[i] = 0; end
            else if (lv[i] != m_hold[i]) begin
               if (m_run[i] >= STB - 1) begin m_hold[i] = lv[i]; m_run[i] = 0; end
               else m_run[i]++;
            end else m_run[i] = 0;
         end
         q_sda.push_front(sda_in); void'(q_sda.pop_back());
         q_scl.push_front(scl_in); void'(q_scl.pop_back());
      end
   end

   // counters observed on the falling edge
   int n_start = 0, n_stop = 0, n_sda_f_low = 0, n_scl_f_low = 0, n_sda_l_low = 0;

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk(sda_filt == mf_sda(), "R2 model sda_filt", sda_filt, mf_sda());
         chk(scl_filt == mf_scl(), "R2 model scl_filt", scl_filt, mf_scl());
         chk(start_pulse == m_start(), "R3 model start_pulse", start_pulse, m_start());
         chk(stop_pulse == m_stop(), "R4 model stop_pulse", stop_pulse, m_stop());
         chk(sda_level == lvl_sda(), "R5 model sda_level", sda_level, lvl_sda());
         chk(scl_level == lvl_scl(), "R5 model scl_level", scl_level, lvl_scl());
         chk(irq == m_irq, "R6 model irq", irq, m_irq);
         chk(evt_flag == m_evt, "R7 model evt_flag", evt_flag, m_evt);
         chk(unproc_flag == m_unproc, "R8 model unproc_flag", unproc_flag, m_unproc);
         chk(err_flag == m_err, "R9 model err_flag", err_flag, m_err);
         if (start_pulse) n_start++;
         if (stop_pulse)  n_stop++;
         if (!sda_filt)   n_sda_f_low++;
         if (!scl_filt)   n_scl_f_low++;
         if (!sda_level)  n_sda_l_low++;
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #2;
   endtask

   task automatic lines(input bit d, input bit c);
      @(posedge clk); #2;
      sda_in = d; scl_in = c;
      idle(8);
   endtask

   task automatic report();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      #(200000 * 20);
      chk(1'b0, "watchdog", 0, 1);
      report();
   end

   initial begin
      int s0, p0, f0, g0, l0;
      idle(3);
      // R11: reset state (sampled while reset is still applied)
      chk(irq == 0 && evt_flag == 0 && err_flag == 0 && unproc_flag == 0,
          "R11 reset flags", {irq, evt_flag, err_flag, unproc_flag}, 0);
      chk(sda_filt && scl_filt && sda_level && scl_level && !start_pulse && !stop_pulse,
          "R11 reset lines", {sda_filt, scl_filt, sda_level, scl_level}, 15);
      rst_n = 1'b1;
      idle(4);

      // R1: exact bypass latency
      @(posedge clk); #2; sda_in = 0; scl_in = 1;
      @(negedge clk);
      @(negedge clk); chk(sda_filt == 1, "R1 before latency", sda_filt, 1);
      @(negedge clk); chk(sda_filt == 0, "R1 after latency", sda_filt, 0);
      idle(6);
      sda_in = 1; idle(8);
      // R1: one-cycle pulse passes and makes a START
      s0 = n_start;
      @(posedge clk); #2; sda_in = 0; @(posedge clk); #2; sda_in = 1; idle(8);
      chk(n_start == s0 + 1, "R1 short pulse passes", n_start - s0, 1);

      // R2: filtered latency and rejection
      filt_en = 1; idle(4);
      @(posedge clk); #2; sda_in = 0;
      @(negedge clk);
      @(negedge clk); @(negedge clk);
      @(negedge clk); chk(sda_filt == 1, "R2 before filter latency", sda_filt, 1);
      @(negedge clk); chk(sda_filt == 0, "R2 after filter latency", sda_filt, 0);
      idle(6);
      sda_in = 1; idle(8);
      s0 = n_start; f0 = n_sda_f_low; g0 = n_scl_f_low; l0 = n_sda_l_low;
      @(posedge clk); #2; sda_in = 0; @(posedge clk); #2; sda_in = 1; idle(8);
      @(posedge clk); #2; scl_in = 0; @(posedge clk); #2; scl_in = 1; idle(8);
      chk(n_sda_f_low == f0, "R2 sda spike rejected", n_sda_f_low - f0, 0);
      chk(n_scl_f_low == g0, "R2 scl spike rejected", n_scl_f_low - g0, 0);
      chk(n_start == s0, "R2 no START from spike", n_start - s0, 0);
      chk(n_sda_l_low == l0 + 1, "R5 level shows spike", n_sda_l_low - l0, 1);

      // R3/R4/R6/R7: full frame, STOP interrupt disabled
      s0 = n_start; p0 = n_stop;
      lines(0, 1); lines(0, 0); lines(1, 0); lines(1, 1); lines(1, 0);
      lines(0, 0); lines(0, 1); lines(1, 1);
      chk(n_start == s0 + 1, "R3 one START", n_start - s0, 1);
      chk(n_stop == p0 + 1, "R4 one STOP", n_stop - p0, 1);
      chk(irq == 0, "R6 STOP with irq disabled", irq, 0);

      // R6/R7: STOP interrupt enabled, event flag stays low
      stop_irq_en = 1;
      lines(0, 1); lines(0, 0); lines(0, 1); lines(1, 1);
      chk(irq == 1, "R6 STOP raises irq", irq, 1);
      chk(evt_flag == 0, "R7 STOP leaves evt low", evt_flag, 0);
      idle(5);
      chk(irq == 1, "R11 irq held", irq, 1);
      @(posedge clk); #2; flag_clr = 1; @(posedge clk); #2; flag_clr = 0; idle(1);
      chk(irq == 0, "R11 clear strobe", irq, 0);

      // R7: byte and error strobes
      @(posedge clk); #2; byte_done = 1; @(posedge clk); #2; byte_done = 0; idle(1);
      chk(evt_flag == 1 && irq == 1 && err_flag == 0, "R7 byte_done", {evt_flag, irq, err_flag}, 6);
      @(posedge clk); #2; arb_lost = 1; @(posedge clk); #2; arb_lost = 0; idle(1);
      chk(err_flag == 1, "R7 arb_lost sets err", err_flag, 1);
      @(posedge clk); #2; flag_clr = 1; bus_err = 1; @(posedge clk); #2; flag_clr = 0; bus_err = 0; idle(1);
      chk(err_flag == 1 && evt_flag == 1, "R11 set wins over clear", {err_flag, evt_flag}, 3);
      @(posedge clk); #2; flag_clr = 1; @(posedge clk); #2; flag_clr = 0; idle(1);

      // R8/R9: repeated START requested, SCL falls instead
      adv_en = 1;
      lines(0, 1); lines(0, 0); lines(1, 0); lines(1, 1);
      @(posedge clk); #2; rstart_req = 1; @(posedge clk); #2; rstart_req = 0; idle(2);
      lines(1, 0);
      chk(unproc_flag == 1, "R8 unprocessed set", unproc_flag, 1);
      chk(err_flag == 1, "R9 unprocessed forces err", err_flag, 1);
      @(posedge clk); #2; flag_clr = 1; @(posedge clk); #2; flag_clr = 0; idle(1);
      chk(unproc_flag == 0, "R8 unprocessed cleared", unproc_flag, 0);

      // R8: requested STOP appears
      lines(0, 0); lines(0, 1);
      @(posedge clk); #2; stop_req = 1; @(posedge clk); #2; stop_req = 0; idle(2);
      lines(1, 1); lines(1, 0); lines(1, 1);
      chk(unproc_flag == 0, "R8 honoured STOP", unproc_flag, 0);

      // R10: advanced features off
      adv_en = 0;
      @(posedge clk); #2; rstart_req = 1; @(posedge clk); #2; rstart_req = 0; idle(2);
      lines(1, 0);
      chk(unproc_flag == 0, "R10 no flag when disabled", unproc_flag, 0);
      adv_en = 1; lines(1, 1); lines(1, 0);
      chk(unproc_flag == 0, "R10 request was dropped", unproc_flag, 0);

      idle(10);
      report();
   end
endmodule